// File: doc/BRIEF.md
# Locking Packet Timestamp Capture Register

This block holds the time value at which a timing event message crossed the media interface. One copy sits on the transmit side and one on the receive side. When a start-of-frame strobe arrives while capture is enabled and no stamp is pending, the free-running 64-bit time is copied into a low and a high 32-bit holding word, and a pending flag is raised together with a one-cycle ready pulse that can feed an interrupt.

While a stamp is pending the block is locked: every further strobe is dropped, so the held value always belongs to exactly one frame. Software fetches the low word first and then the high word; fetching the high word releases the lock. Fetching only the high word is therefore enough to clear a stamp left behind by a frame that was later discarded. The held value is also presented as a 16-byte buffer prefix, in the layout used when the stamp travels in front of a received frame.

Top module: `tstamp_lock_capture`

## Requirements
- R1: When `sof_strobe` and `cap_en` are high, `stamp_pending` is low and `rd_hi` is low, then in the next cycle `stamp_pending` is 1 and the held words equal the low and high halves of `time_now` from the strobe cycle.
- R2: While `stamp_pending` is 1, strobes are dropped: the held words do not change and `stamp_pending` stays 1 until a high-word read.
- R3: With `cap_en` low, a strobe takes no stamp: `stamp_pending` stays 0 and the held words keep their value.
- R4: `rd_data` shows the held low word while `rd_lo` is high and the held high word while `rd_hi` is high, in the same cycle; with neither high it is zero.
- R5: A cycle with `rd_hi` high makes `stamp_pending` 0 in the next cycle, and a later qualifying strobe captures again; the held words are not cleared by the read.
- R6: A low-word read alone leaves `stamp_pending` unchanged.
- R7: When `rd_hi` and a strobe fall in the same cycle, the read wins: `stamp_pending` is 0 next cycle and the strobe's time is not stored, whether or not a stamp was pending.
- R8: `ready_pulse` is 1 for exactly the first cycle in which `stamp_pending` is 1 after having been 0.
- R9: `pkt_prefix` is 16 bytes, byte k at bits [8k+7:8k]: bytes 0 to 7 are zero, bytes 8 to 11 are the held low word least significant byte first, bytes 12 to 15 the held high word least significant byte first.
- R10: While `rst_n` is low, `stamp_pending`, `ready_pulse` and both held words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable |
| sof_strobe | input | 1 | Qualifying start-of-frame event, one cycle |
| time_now | input | 64 | Current time counter value |
| rd_lo | input | 1 | Low-word read strobe |
| rd_hi | input | 1 | High-word read strobe, releases the lock |
| rd_data | output | 32 | Selected held word |
| stamp_pending | output | 1 | A stamp is held and the capture is locked |
| ready_pulse | output | 1 | One-cycle pulse when a stamp is taken |
| pkt_prefix | output | 128 | Held stamp in buffer-prefix byte layout |

## Verification
The hardest situations to reach are those where a release and a new event coincide: a high-word read in the same cycle as a strobe, both while locked and while idle, and strobes arriving back to back right after a capture. The stimulus table places strobes on consecutive cycles with different time values, puts a read and a strobe in one row, and follows each release with a fresh strobe so that a wrongly kept or wrongly dropped stamp shows up in the prefix bytes and the read data.

// File: rtl/tsl_pkg.sv
`timescale 1ns/1ps
package tsl_pkg;
  localparam int TSL_WORD_W = 32;

  // Capture decision: an enabled strobe is taken only when unlocked and not
  // colliding with a high-word read (the read has priority).
  function automatic logic take_now(input logic en, input logic sof,
                                    input logic locked, input logic hi_read);
    return en & sof & ~locked & ~hi_read;
  endfunction

  // Next state of the lock flag.
  function automatic logic lock_next(input logic locked, input logic take,
                                     input logic hi_read);
    if (hi_read) return 1'b0;
    if (take) return 1'b1;
    return locked;
  endfunction
endpackage

// File: rtl/tsl_lock_ctrl.sv
`timescale 1ns/1ps
module tsl_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic sof_strobe,
  input  logic rd_hi,
  output logic take,
  output logic locked_q,
  output logic ready_q
);
  import tsl_pkg::*;

  always_comb take = take_now(cap_en, sof_strobe, locked_q, rd_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      locked_q <= lock_next(locked_q, take, rd_hi);
      ready_q  <= take;
    end
  end

  AST_HI_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> !locked_q); // R5
  AST_DISABLED_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && !cap_en) |=> !locked_q); // R3
  AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !rd_hi) |=> locked_q); // R2
  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> ready_q); // R8
  AST_PULSE_ONLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q); // R8
endmodule

// File: rtl/tsl_hold_regs.sv
`timescale 1ns/1ps
module tsl_hold_regs #(
  parameter int WORD_W = 32,
  localparam int TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [TIME_W-1:0] time_now,
  output logic [WORD_W-1:0] lo_q,
  output logic [WORD_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (take) begin
      lo_q <= time_now[WORD_W-1:0];
      hi_q <= time_now[TIME_W-1:WORD_W];
    end
  end
endmodule

// File: rtl/tsl_prefix_fmt.sv
`timescale 1ns/1ps
module tsl_prefix_fmt #(
  parameter int WORD_W = 32,
  localparam int BPW   = WORD_W / 8,
  localparam int NBYTE = 4 * BPW
) (
  input  logic [WORD_W-1:0]  lo,
  input  logic [WORD_W-1:0]  hi,
  output logic [8*NBYTE-1:0] prefix
);
  // Two reserved words, then the stamp low word and high word, each little-endian.
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    if (b < 2 * BPW) begin : g_rsvd
      assign prefix[8*b +: 8] = 8'h00;
    end else if (b < 3 * BPW) begin : g_low
      assign prefix[8*b +: 8] = lo[8*(b - 2*BPW) +: 8];
    end else begin : g_high
      assign prefix[8*b +: 8] = hi[8*(b - 3*BPW) +: 8];
    end
  end
endmodule

// File: rtl/tstamp_lock_capture.sv
`timescale 1ns/1ps
module tstamp_lock_capture #(
  parameter int WORD_W = tsl_pkg::TSL_WORD_W,
  localparam int TIME_W = 2 * WORD_W,
  localparam int PFX_W  = 4 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              sof_strobe,
  input  logic [TIME_W-1:0] time_now,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [WORD_W-1:0] rd_data,
  output logic              stamp_pending,
  output logic              ready_pulse,
  output logic [PFX_W-1:0]  pkt_prefix
);
  logic              take;
  logic              locked_q;
  logic              ready_q;
  logic [WORD_W-1:0] hold_lo;
  logic [WORD_W-1:0] hold_hi;

  tsl_lock_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .sof_strobe (sof_strobe),
    .rd_hi      (rd_hi),
    .take       (take),
    .locked_q   (locked_q),
    .ready_q    (ready_q)
  );

  tsl_hold_regs #(.WORD_W(WORD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .time_now (time_now),
    .lo_q     (hold_lo),
    .hi_q     (hold_hi)
  );

  tsl_prefix_fmt #(.WORD_W(WORD_W)) u_pfx (
    .lo     (hold_lo),
    .hi     (hold_hi),
    .prefix (pkt_prefix)
  );

  always_comb begin
    rd_data = ({WORD_W{rd_lo}} & hold_lo) | ({WORD_W{rd_hi}} & hold_hi);
  end

  assign stamp_pending = locked_q;
  assign ready_pulse   = ready_q;

  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_strobe && cap_en && !stamp_pending && !rd_hi)
      |=> ({hold_hi, hold_lo} == $past(time_now))); // R1
  AST_LOCKED_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_pending |=> ($stable(hold_lo) && $stable(hold_hi))); // R2
  AST_COLLIDE_READ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && sof_strobe) |=> (!stamp_pending && $stable(hold_hi))); // R7
  AST_LO_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi && stamp_pending) |=> stamp_pending); // R6
endmodule

// File: tb/tstamp_lock_capture_test.sv
`timescale 1ns/1ps
module tstamp_lock_capture_test;
  localparam int W  = 32;
  localparam int NV = 14;

  // Row: req[41:38] en[37] sof[36] rlo[35] rhi[34] tag[33:18] exp_valid[17] exp_pulse[16] exp_tag[15:0]
  typedef logic [41:0] vec_t;
  localparam vec_t VECS [NV] = '{
    {4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0011, 1'b1, 1'b1, 16'h0011}, // R1 first capture, R8 pulse
    {4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0022, 1'b1, 1'b0, 16'h0011}, // R2 back-to-back strobe dropped
    {4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0033, 1'b1, 1'b0, 16'h0011}, // R2 again
    {4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 16'h00AA, 1'b1, 1'b0, 16'h0011}, // R6 low read keeps lock
    {4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 16'h00AA, 1'b0, 1'b0, 16'h0011}, // R5 high read releases
    {4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0044, 1'b0, 1'b0, 16'h0011}, // R3 disabled strobe
    {4'd7, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0055, 1'b0, 1'b0, 16'h0011}, // R7 collide while idle
    {4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0066, 1'b1, 1'b1, 16'h0066}, // R5 relock after release
    {4'd7, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0077, 1'b0, 1'b0, 16'h0066}, // R7 collide while locked
    {4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00AA, 1'b0, 1'b0, 16'h0066}, // R7 stays released
    {4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0088, 1'b1, 1'b1, 16'h0088}, // R1 capture
    {4'd2, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0099, 1'b1, 1'b0, 16'h0088}, // R2 strobe with low read
    {4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 16'h00AA, 1'b0, 1'b0, 16'h0088}, // R5 high-word-only release
    {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00AA, 1'b0, 1'b0, 16'h0088}  // R8 no pulse when idle
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cap_en, sof_strobe, rd_lo, rd_hi;
  logic [63:0]   time_now;
  logic [W-1:0]  rd_data;
  logic          stamp_pending, ready_pulse;
  logic [127:0]  pkt_prefix;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  tstamp_lock_capture uut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .sof_strobe(sof_strobe),
    .time_now(time_now), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data),
    .stamp_pending(stamp_pending), .ready_pulse(ready_pulse), .pkt_prefix(pkt_prefix)
  );

  function automatic logic [63:0] stamp_of(input logic [15:0] t);
    if (t == 16'h0000) return 64'h0;
    return {16'hC0DE, t, ~t, 16'h0F1E};
  endfunction

  function automatic logic [127:0] prefix_of(input logic [63:0] s);
    logic [127:0] p;
    p = '0;
    for (int k = 8; k < 16; k++) p[8*k +: 8] = s[8*(k-8) +: 8];
    return p;
  endfunction

  task automatic chk(input string what, input int req, input logic [127:0] got,
                     input logic [127:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic en, input logic sof, input logic rl,
                       input logic rh, input logic [15:0] tag);
    cap_en = en; sof_strobe = sof; rd_lo = rl; rd_hi = rh; time_now = stamp_of(tag);
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] prev_tag;
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 1'b0, 1'b0, 16'h0F0F);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state, even with a strobe applied
    chk("pending in reset", 10, {127'b0, stamp_pending}, 128'h0);
    chk("pulse in reset", 10, {127'b0, ready_pulse}, 128'h0);
    chk("prefix in reset", 10, pkt_prefix, 128'h0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h00AA);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("rd_data idle", 4, {96'b0, rd_data}, 128'h0); // R4

    prev_tag = 16'h0000;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [63:0] ps;
      v = VECS[i];
      drive(v[37], v[36], v[35], v[34], v[33:18]);
      #1;
      ps = stamp_of(prev_tag);
      if (v[35]) chk("rd_data low word", 4, {96'b0, rd_data}, {96'b0, ps[31:0]});  // R4
      if (v[34]) chk("rd_data high word", 4, {96'b0, rd_data}, {96'b0, ps[63:32]}); // R4
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("row %0d pending", i), int'(v[41:38]), {127'b0, stamp_pending}, {127'b0, v[17]});
      chk($sformatf("row %0d pulse", i), int'(v[41:38]), {127'b0, ready_pulse}, {127'b0, v[16]});
      chk($sformatf("row %0d prefix", i), 9, pkt_prefix, prefix_of(stamp_of(v[15:0]))); // R9
      prev_tag = v[15:0];
    end

    // R9: explicit byte positions of a fresh capture
    drive(1'b1, 1'b1, 1'b0, 1'b0, 16'h1357);
    @(posedge clk);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h00AA);
    chk("reserved bytes 0-7", 9, {64'b0, pkt_prefix[63:0]}, 128'h0);
    chk("byte 8 is low LSB", 9, {120'b0, pkt_prefix[71:64]}, {120'b0, 8'h1E});
    chk("byte 15 is high MSB", 9, {120'b0, pkt_prefix[127:120]}, {120'b0, 8'hC0});

    // R10: reset while a stamp is pending
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("pending after reset", 10, {127'b0, stamp_pending}, 128'h0);
    chk("prefix after reset", 10, pkt_prefix, 128'h0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule